// File: doc/BRIEF.md
# Reloadable DMA Transfer Counter

This block holds the byte count for a DMA data phase. The host programs a start count one byte at a time through three byte-wide slots (low, middle, high). These writes go into a start-count image. The working counter that a data-movement engine consumes is a separate register. A command issued with its DMA flag set copies the image into the working counter. An image of zero is loaded as 65536. Host reads always return the working counter, never the image.

The data-movement engine decrements the working counter by one or two bytes per request, and the counter saturates at zero. A terminal-count status bit is set when the counter reaches zero, or when the engine ends the phase early, which also forces the counter to zero. Terminal count is cleared by any write to a count byte and by a transfer command issued with DMA. Until software first writes the high count byte after reset, reads of that byte return a fixed identification value, so drivers can probe which part they are talking to.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset the working counter and the start image are zero, `tc_o` is 0, and reading the high slot (select 2) returns `CHIP_ID`.
- R2: A write to slot 0, 1 or 2 updates bits [7:0], [15:8] or [23:16] of the start image only, and leaves the working counter unchanged.
- R3: A cycle with `cmd_we_i`=1 and `cmd_dma_i`=1 loads the working counter from the start image as it was before that cycle. An image of zero loads 0x10000. A command with `cmd_dma_i`=0 leaves the counter unchanged.
- R4: Reads are combinational. Select 0, 1 and 2 return bits [7:0], [15:8] and [23:16] of the working counter. Select 3 reads 0, and writes to select 3 are ignored.
- R5: A read of select 2 returns `CHIP_ID` until select 2 has been written at least once since reset, and the counter's high byte afterwards. Writes to select 0 or 1 do not end this.
- R6: A write to select 0, 1 or 2 clears `tc_o` on the next cycle. This clear wins over a decrement reaching zero in the same cycle.
- R7: A command with `cmd_dma_i`=1 and `cmd_xfer_i`=1 clears `tc_o` and loads the counter as in R3. A DMA command without `cmd_xfer_i` leaves `tc_o` unchanged.
- R8: `phase_end_i` forces the counter to zero and sets `tc_o`. It overrides loads, decrements and clears in the same cycle.
- R9: `dec_req_i` subtracts 2 when `dec_two_i`=1 and 1 otherwise, saturating at zero. `tc_o` is set in the cycle the counter goes from nonzero to zero. A decrement at zero leaves `tc_o` unchanged.
- R10: When a DMA load and a decrement arrive in the same cycle, the load wins and the decrement is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Count byte write strobe |
| reg_sel_i | input | 2 | Byte slot select (0 low, 1 middle, 2 high) |
| reg_wdata_i | input | 8 | Write data for the start image |
| reg_rdata_o | output | 8 | Readback of the selected working-counter byte or the ID |
| cmd_we_i | input | 1 | Command issue strobe |
| cmd_dma_i | input | 1 | DMA flag of the issued command |
| cmd_xfer_i | input | 1 | Issued command is a transfer command |
| dec_req_i | input | 1 | Decrement request from the data engine |
| dec_two_i | input | 1 | Decrement by two instead of one |
| phase_end_i | input | 1 | Data phase ended; zero counter, set terminal count |
| tc_o | output | 1 | Terminal-count status |

## Verification
The identification readback exists only in the window between reset and the first high-byte write. The bench therefore probes it first. It then reasserts reset mid-run to reopen the window, and checks that low and middle writes do not close it. The other hard cases are same-cycle collisions: a byte write clearing terminal count while a decrement reaches zero, a load racing a decrement, and a phase end racing a load. The bench drives each collision on purpose, after a sweep that loads every start value from 0 to 47 and decrements each one by mixed steps of one and two down to zero and past it.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;
  localparam int BYTE_W = 8;

  function automatic int unsigned sel_width(input int unsigned nbytes);
    return (nbytes <= 2) ? 1 : $clog2(nbytes + 1);
  endfunction
endpackage

// File: rtl/xfer_start_image.sv
module xfer_start_image
  import xfer_cnt_pkg::*;
#(
  parameter int unsigned NBYTES = 3,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned CNT_W = NBYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  start_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (we_i && sel_i == SEL_W'(b)) byte_q <= wdata_i;
    end
    assign start_o[b*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/xfer_work_counter.sv
module xfer_work_counter #(
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned RELOAD_VAL = 32'h1_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             dec_i,
  input  logic             dec_two_i,
  input  logic             zero_i,
  input  logic             tc_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q, load_val, dec_amt, dec_val;
  logic             tc_q, hit_zero;

  assign load_val = (start_i == '0) ? CNT_W'(RELOAD_VAL) : start_i;
  assign dec_amt  = dec_two_i ? CNT_W'(2) : CNT_W'(1);
  assign dec_val  = (cnt_q <= dec_amt) ? '0 : cnt_q - dec_amt;
  // decrement that takes a nonzero count to zero
  assign hit_zero = dec_i && !load_i && (cnt_q != '0) && (dec_val == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (zero_i) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val;
    else if (dec_i)  cnt_q <= dec_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tc_q <= 1'b0;
    else if (zero_i)    tc_q <= 1'b1;
    else if (tc_clr_i)  tc_q <= 1'b0;
    else if (hit_zero)  tc_q <= 1'b1;
  end

  assign cnt_o = cnt_q;
  assign tc_o  = tc_q;
endmodule

// File: rtl/xfer_readback.sv
module xfer_readback
  import xfer_cnt_pkg::*;
#(
  parameter int unsigned NBYTES  = 3,
  parameter int unsigned SEL_W   = 2,
  parameter logic [7:0]  CHIP_ID = 8'hA2,
  localparam int unsigned CNT_W  = NBYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              hi_seen_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(NBYTES - 1);
  logic hi_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hi_seen_q <= 1'b0;
    else if (we_i && sel_i == HI_SEL) hi_seen_q <= 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBYTES; b++)
      if (sel_i == SEL_W'(b)) rdata_o = cnt_i[b*BYTE_W +: BYTE_W];
    if (sel_i == HI_SEL && !hi_seen_q) rdata_o = CHIP_ID;
  end

  assign hi_seen_o = hi_seen_q;
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
  import xfer_cnt_pkg::*;
#(
  parameter int unsigned NBYTES     = 3,
  parameter int unsigned RELOAD_VAL = 32'h1_0000,
  parameter logic [7:0]  CHIP_ID    = 8'hA2,
  localparam int unsigned CNT_W     = NBYTES * BYTE_W,
  localparam int unsigned SEL_W     = sel_width(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              cmd_we_i,
  input  logic              cmd_dma_i,
  input  logic              cmd_xfer_i,
  input  logic              dec_req_i,
  input  logic              dec_two_i,
  input  logic              phase_end_i,
  output logic              tc_o
);
  logic [CNT_W-1:0] start_cnt, work_cnt;
  logic             sel_ok, byte_wr, dma_load, tc_clr, hi_seen;

  assign sel_ok   = reg_sel_i < SEL_W'(NBYTES);
  assign byte_wr  = reg_we_i && sel_ok;
  assign dma_load = cmd_we_i && cmd_dma_i;
  assign tc_clr   = byte_wr || (dma_load && cmd_xfer_i);

  xfer_start_image #(.NBYTES(NBYTES), .SEL_W(SEL_W)) u_image (
    .clk_i, .rst_ni, .we_i(byte_wr), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .start_o(start_cnt)
  );

  xfer_work_counter #(.CNT_W(CNT_W), .RELOAD_VAL(RELOAD_VAL)) u_counter (
    .clk_i, .rst_ni, .load_i(dma_load), .start_i(start_cnt),
    .dec_i(dec_req_i), .dec_two_i, .zero_i(phase_end_i),
    .tc_clr_i(tc_clr), .cnt_o(work_cnt), .tc_o
  );

  xfer_readback #(.NBYTES(NBYTES), .SEL_W(SEL_W), .CHIP_ID(CHIP_ID)) u_read (
    .clk_i, .rst_ni, .we_i(byte_wr), .sel_i(reg_sel_i),
    .cnt_i(work_cnt), .hi_seen_o(hi_seen), .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/dma_xfer_counter_chk.sv
module dma_xfer_counter_chk #(
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned RELOAD_VAL = 32'h1_0000,
  parameter logic [7:0]  CHIP_ID    = 8'hA2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [SEL_W-1:0] reg_sel_i,
  input logic [7:0]       reg_rdata_o,
  input logic             cmd_we_i,
  input logic             cmd_dma_i,
  input logic             cmd_xfer_i,
  input logic             dec_req_i,
  input logic             phase_end_i,
  input logic             tc_o,
  input logic [CNT_W-1:0] work_cnt,
  input logic [CNT_W-1:0] start_cnt,
  input logic             hi_seen
);
  localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(CNT_W / 8 - 1);

  // R8
  phase_end_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_end_i |=> (work_cnt == '0) && tc_o);

  // R3
  dma_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_dma_i && !phase_end_i) |=>
      work_cnt == (($past(start_cnt) == '0) ? CNT_W'(RELOAD_VAL) : $past(start_cnt)));

  // R6
  wr_clears_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i <= HI_SEL && !phase_end_i) |=> !tc_o);

  // R7
  xfer_clears_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_dma_i && cmd_xfer_i && !phase_end_i) |=> !tc_o);

  // R9
  dec_no_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_req_i && !(cmd_we_i && cmd_dma_i) && !phase_end_i) |=> work_cnt <= $past(work_cnt));

  // R2
  image_wr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !cmd_we_i && !dec_req_i && !phase_end_i) |=> $stable(work_cnt));

  // R5
  chip_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_seen && reg_sel_i == HI_SEL) |-> reg_rdata_o == CHIP_ID);
endmodule

bind dma_xfer_counter dma_xfer_counter_chk #(
  .CNT_W(CNT_W), .SEL_W(SEL_W), .RELOAD_VAL(RELOAD_VAL), .CHIP_ID(CHIP_ID)
) u_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_rdata_o, .cmd_we_i, .cmd_dma_i,
  .cmd_xfer_i, .dec_req_i, .phase_end_i, .tc_o, .work_cnt, .start_cnt, .hi_seen
);

// File: tb/dma_xfer_counter_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_counter_tb_top;
  localparam logic [7:0] ID = 8'hA2;

  logic       clk_i = 0, rst_ni = 0;
  logic       reg_we_i = 0, cmd_we_i = 0, cmd_dma_i = 0, cmd_xfer_i = 0;
  logic       dec_req_i = 0, dec_two_i = 0, phase_end_i = 0;
  logic [1:0] reg_sel_i = 0;
  logic [7:0] reg_wdata_i = 0, reg_rdata_o;
  logic       tc_o;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [23:0] m_cnt, m_start;
  bit m_tc, m_hiw;

  always #2 clk_i = ~clk_i;

  dma_xfer_counter #(.CHIP_ID(ID)) dut_i (.*);

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    reg_sel_i = 2'd0; #0.1 chk({tag, " R4 lo"}, 24'(reg_rdata_o), 24'(m_cnt[7:0]));
    reg_sel_i = 2'd1; #0.1 chk({tag, " R4 mid"}, 24'(reg_rdata_o), 24'(m_cnt[15:8]));
    reg_sel_i = 2'd2; #0.1 chk({tag, " R5 hi"}, 24'(reg_rdata_o),
                               24'(m_hiw ? m_cnt[23:16] : ID));
    chk({tag, " tc"}, 24'(tc_o), 24'(m_tc));
  endtask

  task automatic model_reset();
    m_cnt = 0; m_start = 0; m_tc = 0; m_hiw = 0;
  endtask

  // one clock with any combination of stimuli; model mirrors the requirements
  task automatic step(bit we, logic [1:0] sel, logic [7:0] wd, bit cw, bit dma,
                      bit xf, bit dec, bit two, bit pend);
    logic [23:0] amt, dv, nstart;
    bit load, clr;
    @(negedge clk_i);
    reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd; cmd_we_i = cw;
    cmd_dma_i = dma; cmd_xfer_i = xf; dec_req_i = dec; dec_two_i = two;
    phase_end_i = pend;
    @(posedge clk_i);
    #0.5;
    reg_we_i = 0; cmd_we_i = 0; cmd_dma_i = 0; cmd_xfer_i = 0;
    dec_req_i = 0; dec_two_i = 0; phase_end_i = 0;
    load = cw && dma;
    clr = (we && sel != 2'd3) || (load && xf);
    amt = two ? 24'd2 : 24'd1;
    dv = (m_cnt <= amt) ? 24'd0 : m_cnt - amt;
    nstart = m_start;
    if (we && sel != 2'd3) nstart[sel*8 +: 8] = wd;
    if (we && sel == 2'd2) m_hiw = 1;
    if (pend) m_tc = 1;
    else if (clr) m_tc = 0;
    else if (dec && !load && m_cnt != 0 && dv == 0) m_tc = 1;
    if (pend) m_cnt = 0;
    else if (load) m_cnt = (m_start == 0) ? 24'h010000 : m_start;
    else if (dec) m_cnt = dv;
    m_start = nstart;
  endtask

  task automatic write_start(logic [23:0] v);
    step(1, 2'd0, v[7:0], 0, 0, 0, 0, 0, 0);
    step(1, 2'd1, v[15:8], 0, 0, 0, 0, 0, 0);
    step(1, 2'd2, v[23:16], 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    #0.5 check_all("R1 reset");
    rst_ni = 1;
    // R5: lo/mid writes keep the ID visible; R2: counter untouched
    step(1, 2'd0, 8'h33, 0, 0, 0, 0, 0, 0);
    step(1, 2'd1, 8'h44, 0, 0, 0, 0, 0, 0);
    check_all("R5 id kept R2");
    step(1, 2'd3, 8'hFF, 0, 0, 0, 0, 0, 0);
    reg_sel_i = 2'd3; #0.1 chk("R4 sel3 reads zero", 24'(reg_rdata_o), 24'd0);
    step(1, 2'd2, 8'h05, 0, 0, 0, 0, 0, 0);
    check_all("R5 hi unlocked R2");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    check_all("R3 no dma no load");
    step(0, 0, 0, 1, 1, 0, 0, 0, 0);
    check_all("R3 load");
    // sweep of small start values, including zero
    for (int s = 0; s < 48; s++) begin
      write_start(24'(s));
      step(0, 0, 0, 1, 1, s[0], 0, 0, 0);
      check_all("R3 R7 sweep load");
      if (s != 0) begin
        for (int k = 0; k < 60 && (k == 0 || m_cnt != 0); k++) begin
          step(0, 0, 0, 0, 0, 0, 1, (k % 3) == 1, 0);
          check_all("R9 dec");
        end
        step(0, 0, 0, 0, 0, 0, 1, 1, 0);
        check_all("R9 dec at zero");
        step(0, 0, 0, 1, 1, 0, 0, 0, 0);
        check_all("R7 dma no xfer keeps tc");
        step(0, 0, 0, 1, 1, 1, 0, 0, 0);
        check_all("R7 xfer clears tc");
      end
    end
    // wide values
    foreach (m_start[i]) ;
    for (int w = 0; w < 6; w++) begin
      logic [23:0] v;
      v = 24'hFFFFFF - 24'(w) * 24'h2B3C4D;
      write_start(v);
      step(0, 0, 0, 1, 1, 0, 0, 0, 0);
      check_all("R3 wide load");
      step(0, 0, 0, 0, 0, 0, 1, 1, 0);
      check_all("R9 wide dec2");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1);
      check_all("R8 phase end");
      step(1, 2'd1, 8'h00, 0, 0, 0, 0, 0, 0);
      check_all("R6 write clears tc");
    end
    // collisions
    write_start(24'd1);
    step(0, 0, 0, 1, 1, 0, 0, 0, 0);
    step(1, 2'd0, 8'h09, 0, 0, 0, 1, 0, 0);
    check_all("R6 clear beats dec to zero");
    write_start(24'd7);
    step(0, 0, 0, 1, 1, 0, 1, 1, 0);
    check_all("R10 load beats dec");
    step(0, 0, 0, 1, 1, 1, 1, 0, 1);
    check_all("R8 phase end beats load");
    // reset mid-run reopens the ID window
    @(negedge clk_i) rst_ni = 0;
    model_reset();
    #1 check_all("R1 second reset");
    @(negedge clk_i) rst_ni = 1;
    step(1, 2'd0, 8'h02, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0, 0, 0);
    check_all("R5 id after reset with load");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule